// File: doc/BRIEF.md
# Two-Wire Byte Memory Slave

This block is the slave side of a small byte memory of sixteen 8-bit locations, reached over a two-wire serial link made of a clock line and a bidirectional data line. The protocol has no acknowledge cycles and no device address. Every transaction opens with a start condition and an 8-bit control byte. In that byte a 2-bit command selects write or read and a 4-bit field selects the location. A write then takes in one data byte and holds the block busy for a fixed time. A read drives one data byte back to the master through a push-pull pad.

The block runs on a fast system clock. It passes both bus lines through two-flop synchronizers and finds clock edges, start conditions and stop conditions on the synchronized values. The memory is a register array inside the block. The self-timed write is modelled as a countdown of `WR_CYCLES` system clocks. The pad is driven from `sda_out`, gated by `sda_oe`.

Top module: `twowire_bytemem`

## Requirements
- R1: After reset `sda_oe` and `sda_out` are 0, the block waits for a start, and every memory location reads back as 0x00.
- R2: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. Clock pulses that come before the first start are ignored and write nothing.
- R3: The control byte is sampled on clock rising edges, MSB first, as bits [7:6] command, [5:2] address, [1:0] ignored. Command 01 is a write and command 10 is a read.
- R4: After a write control byte, the next 8 rising edges shift in data MSB first. On the eighth edge the byte is stored at the addressed location, and no other location changes.
- R5: From the eighth write data bit, the block ignores every input, starts and stops included, for `WR_CYCLES` system clocks. It then waits for a new start. It never drives the pad while busy.
- R6: After a read control byte, the addressed byte is put on `sda_out` MSB first. Bit 7 appears after the falling clock edge that closes the eighth control clock, and each following bit appears after the next falling edge. `sda_oe` drops after the falling edge that follows the eighth data clock.
- R7: A start during the control byte or the write data discards the partial input and begins a new control byte. A stop there discards it and returns to waiting for a start. An aborted write leaves memory unchanged.
- R8: Starts and stops are ignored from the seventh control rising edge until the eighth, and during the whole read output phase.
- R9: Command codes 00 and 11 are invalid. The block then ignores all clock pulses until the next start or stop, writes nothing and never drives the pad.
- R10: `sda_oe` is high only during the read output phase, and `sda_out` is 0 whenever `sda_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line from the master |
| sda_in | input | 1 | Serial data line as seen at the pad input |
| sda_out | output | 1 | Data bit driven onto the data line during reads |
| sda_oe | output | 1 | Pad output enable for the data line |

## Verification
The checker watches, on every cycle, the properties that only need a short history. The pad is quiet while disabled. An output bit changes only right after a detected clock fall. The busy window never exceeds `WR_CYCLES` and never drives the pad. A start or stop seen during output does not release the pad. The bench scenarios show the effects that span whole transactions. These are that bytes written at the edge addresses read back intact, that aborted or invalid or busy-time writes leave memory unchanged, and that locked-out starts and stops leave a read byte whole.

// File: rtl/twowire_bytemem.sv
module twowire_bytemem #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int DC_W      = 2,
  parameter int WR_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_out,
  output logic sda_oe
);
  localparam int CMD_W  = 2;
  localparam int CTRL_W = CMD_W + ADDR_W + DC_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int MAXB   = (CTRL_W > DATA_W) ? CTRL_W : DATA_W;
  localparam int CW     = $clog2(MAXB);
  localparam int TW     = $clog2(WR_CYCLES + 1);
  localparam logic [CMD_W-1:0] CMD_WR = 2'b01;
  localparam logic [CMD_W-1:0] CMD_RD = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_WDAT, S_BUSY, S_RDAT, S_SKIP} state_t;

  logic [1:0] scl_sync, sda_sync;
  logic       scl_q, sda_q;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_det, stop_det;

  state_t              state;
  logic [CW-1:0]       bit_cnt;
  logic [CTRL_W-1:0]   ctrl_sh;
  logic [DATA_W-1:0]   dat_sh;
  logic [ADDR_W-1:0]   addr_q;
  logic [TW-1:0]       tmr;
  logic                drv;
  logic [DATA_W-1:0]   mem [DEPTH];

  logic [CTRL_W-1:0]   ctrl_next;
  logic [CMD_W-1:0]    cmd;
  logic [ADDR_W-1:0]   rd_addr;
  logic [DATA_W-1:0]   wr_data;
  logic                wr_en, lock, busy, ctrl_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_in};
      sda_sync <= {sda_sync[0], sda_in};
      scl_q    <= scl_sync[1];
      sda_q    <= sda_sync[1];
    end
  end

  assign scl_s     = scl_sync[1];
  assign sda_s     = sda_sync[1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  assign ctrl_next = {ctrl_sh[CTRL_W-2:0], sda_s};
  assign cmd       = ctrl_next[CTRL_W-1 -: CMD_W];
  assign rd_addr   = ctrl_next[DC_W +: ADDR_W];
  assign wr_data   = {dat_sh[DATA_W-2:0], sda_s};
  assign ctrl_last = (bit_cnt == CW'(CTRL_W - 1));
  assign busy      = (state == S_BUSY);
  assign lock      = busy || (state == S_RDAT) || (state == S_CTRL && ctrl_last);
  assign wr_en     = (state == S_WDAT) && scl_rise && (bit_cnt == CW'(DATA_W - 1));

  assign sda_oe  = (state == S_RDAT) && drv;
  assign sda_out = sda_oe & dat_sh[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[addr_q] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      bit_cnt <= '0;
      ctrl_sh <= '0;
      dat_sh  <= '0;
      addr_q  <= '0;
      tmr     <= '0;
      drv     <= 1'b0;
    end else if (!lock && start_det) begin
      state   <= S_CTRL;
      bit_cnt <= '0;
    end else if (!lock && stop_det) begin
      state   <= S_IDLE;
      bit_cnt <= '0;
    end else begin
      case (state)
        S_CTRL: if (scl_rise) begin
          ctrl_sh <= ctrl_next;
          if (ctrl_last) begin
            bit_cnt <= '0;
            addr_q  <= rd_addr;
            drv     <= 1'b0;
            if (cmd == CMD_WR) begin
              state <= S_WDAT;
            end else if (cmd == CMD_RD) begin
              state  <= S_RDAT;
              dat_sh <= mem[rd_addr];
            end else begin
              state <= S_SKIP;
            end
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        S_WDAT: if (scl_rise) begin
          dat_sh <= wr_data;
          if (bit_cnt == CW'(DATA_W - 1)) begin
            bit_cnt <= '0;
            tmr     <= TW'(WR_CYCLES - 1);
            state   <= S_BUSY;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        S_BUSY: begin
          if (tmr == '0) state <= S_IDLE;
          else           tmr   <= tmr - 1'b1;
        end
        S_RDAT: if (scl_fall) begin
          if (!drv) begin
            drv <= 1'b1;
          end else if (bit_cnt == CW'(DATA_W - 1)) begin
            drv     <= 1'b0;
            bit_cnt <= '0;
            state   <= S_IDLE;
          end else begin
            dat_sh  <= {dat_sh[DATA_W-2:0], 1'b0};
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

module twowire_bytemem_chk #(
  parameter int WR_CYCLES = 64
) (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic sda_out,
  input logic scl_fall,
  input logic start_det,
  input logic stop_det,
  input logic busy
);
  logic [31:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= '0;
  end

  p_quiet_pad_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sda_oe |-> !sda_out);

  p_bit_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && $past(sda_oe) && (sda_out != $past(sda_out))) |-> $past(scl_fall));

  p_drive_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  p_busy_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  p_busy_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_len <= WR_CYCLES);

  p_output_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && (start_det || stop_det)) |=> sda_oe);
endmodule

bind twowire_bytemem twowire_bytemem_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .sda_out(sda_out),
  .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det), .busy(busy)
);

// File: tb/twowire_bytemem_tb.sv
module twowire_bytemem_tb;
  localparam int H  = 8;
  localparam int WC = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic sda_out, sda_oe;
  logic oe_seen = 1'b0;
  int   total = 0;
  int   bad = 0;

  always #2.5 clk = ~clk;

  twowire_bytemem #(.WR_CYCLES(WC)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
    .sda_out(sda_out), .sda_oe(sda_oe)
  );

  always @(posedge clk) if (sda_oe) oe_seen <= 1'b1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    scl = 0; hold(H); sda = 1; hold(H); scl = 1; hold(H); sda = 0; hold(H); scl = 0; hold(H);
  endtask

  task automatic bus_stop();
    sda = 0; hold(H); scl = 1; hold(H); sda = 1; hold(H);
  endtask

  task automatic send_bit(input bit b);
    sda = b; hold(H); scl = 1; hold(H); scl = 0; hold(H);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) send_bit(v[i]);
  endtask

  task automatic glitch();
    sda = 1; hold(3); sda = 0; hold(4); sda = 1; hold(4);
  endtask

  task automatic write_byte(input logic [3:0] a, input logic [7:0] d);
    bus_start();
    send_bits({2'b01, a, 2'b11}, 8);
    send_bits(d, 8);
  endtask

  task automatic read_byte(input logic [3:0] a, input int glitch_at, output logic [7:0] d);
    logic [7:0] c;
    c = {2'b10, a, 2'b10};
    bus_start();
    send_bits(c, 7);
    sda = c[0]; hold(H); scl = 1; hold(H);
    if (glitch_at == 8) glitch();
    check(sda_oe == 0, "R6 no drive before eighth fall", sda_oe, 0);
    scl = 0; hold(H);
    check(sda_oe == 1, "R6 drive after eighth fall", sda_oe, 1);
    d[7] = sda_out;
    for (int i = 6; i >= 0; i--) begin
      scl = 1; hold(H);
      if (glitch_at == i) glitch();
      scl = 0; hold(H);
      d[i] = sda_out;
    end
    scl = 1; hold(H); scl = 0; hold(H);
    check(sda_oe == 0 && sda_out == 0, "R6 release after last bit", sda_oe, 0);
  endtask

  task automatic t_reset();
    check(sda_oe == 0, "R1 oe after reset", sda_oe, 0);
    check(sda_out == 0, "R1 out after reset", sda_out, 0);
  endtask

  task automatic t_no_start();
    logic [7:0] got;
    oe_seen = 0;
    scl = 0; hold(H);
    send_bits({2'b01, 4'd3, 2'b00}, 8);
    send_bits(8'hFF, 8);
    hold(WC + 50);
    check(oe_seen == 0, "R2 silent without start", oe_seen, 0);
    read_byte(4'd3, -1, got);
    check(got == 8'h00, "R2 R1 no write before start", got, 8'h00);
  endtask

  task automatic t_write_read();
    logic [7:0] got;
    oe_seen = 0;
    write_byte(4'd5, 8'hA5); hold(WC + 50);
    write_byte(4'd15, 8'hC3); hold(WC + 50);
    write_byte(4'd0, 8'h3C); hold(WC + 50);
    check(oe_seen == 0 && sda_out == 0, "R10 no drive during writes", oe_seen, 0);
    read_byte(4'd5, -1, got);
    check(got == 8'hA5, "R3 R4 readback addr 5", got, 8'hA5);
    read_byte(4'd15, -1, got);
    check(got == 8'hC3, "R4 readback addr 15", got, 8'hC3);
    read_byte(4'd0, -1, got);
    check(got == 8'h3C, "R4 readback addr 0", got, 8'h3C);
    read_byte(4'd1, -1, got);
    check(got == 8'h00, "R4 neighbour untouched", got, 8'h00);
  endtask

  task automatic t_busy();
    logic [7:0] got;
    write_byte(4'd2, 8'h11);
    oe_seen = 0;
    write_byte(4'd2, 8'hEE);
    hold(WC + 50);
    check(oe_seen == 0, "R5 silent while busy", oe_seen, 0);
    read_byte(4'd2, -1, got);
    check(got == 8'h11, "R5 write during busy ignored", got, 8'h11);
  endtask

  task automatic t_abort();
    logic [7:0] got;
    bus_start();
    send_bits({2'b01, 4'd7, 2'b00}, 8);
    send_bits(8'hFF, 4);
    bus_stop();
    hold(WC + 50);
    read_byte(4'd7, -1, got);
    check(got == 8'h00, "R7 stop aborts write", got, 8'h00);
    bus_start();
    send_bits({2'b01, 4'd7, 2'b00}, 8);
    send_bits(8'hFF, 3);
    read_byte(4'd5, -1, got);
    check(got == 8'hA5, "R7 start restarts during data", got, 8'hA5);
    read_byte(4'd7, -1, got);
    check(got == 8'h00, "R7 restarted write left memory", got, 8'h00);
    bus_start();
    send_bits({2'b01, 4'd7, 2'b00}, 3);
    read_byte(4'd15, -1, got);
    check(got == 8'hC3, "R7 start restarts during control", got, 8'hC3);
  endtask

  task automatic t_lockout();
    logic [7:0] got;
    read_byte(4'd5, 8, got);
    check(got == 8'hA5, "R8 start stop ignored on eighth clock", got, 8'hA5);
    read_byte(4'd15, 3, got);
    check(got == 8'hC3, "R8 start stop ignored during output", got, 8'hC3);
  endtask

  task automatic t_invalid();
    logic [7:0] got;
    oe_seen = 0;
    bus_start();
    send_bits({2'b11, 4'd5, 2'b00}, 8);
    send_bits(8'h00, 8);
    bus_start();
    send_bits({2'b00, 4'd5, 2'b00}, 8);
    send_bits(8'h00, 8);
    hold(WC + 50);
    check(oe_seen == 0, "R9 invalid command silent", oe_seen, 0);
    read_byte(4'd5, -1, got);
    check(got == 8'hA5, "R9 invalid command writes nothing", got, 8'hA5);
  endtask

  initial begin
    hold(5);
    rst_n = 1;
    hold(5);
    t_reset();
    t_no_start();
    t_write_read();
    t_busy();
    t_abort();
    t_lockout();
    t_invalid();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule